// File: doc/BRIEF.md
# Bidirectional Parity Bus Transceiver

An eight-bit, non-inverting bus transceiver that moves a byte from port A to port B or from port B to port A, selected by a direction input. Both ports can be released together by a high-impedance request, whatever the direction. A ninth pin carries parity and changes role with the direction. While transmitting, the block computes parity over the byte on port A and drives it. While receiving, it reads the parity sent with the byte on port B and checks the nine bits against the selected parity sense. The result appears on an active-low error output.

Each bidirectional pin is split into a data-in, a data-out and a drive-enable signal, so the block stays synthesizable and the pad ring supplies the tri-state buffers. The block is purely combinational and has no clock and no reset. The data width and the shape of the parity tree are parameters.

Top module: `bpt_xcvr`

## Requirements
- R1: With `dir_a2b`=1 and `hiz_req`=0, `b_oe`=1, `a_oe`=0 and `b_out` equals `a_in` bit for bit.
- R2: With `dir_a2b`=0 and `hiz_req`=0, `a_oe`=1, `b_oe`=0 and `a_out` equals `b_in` bit for bit.
- R3: With `hiz_req`=1, `a_oe`, `b_oe` and `par_oe` are all 0 for either value of `dir_a2b`.
- R4: `par_oe` is 1 exactly when `dir_a2b`=1 and `hiz_req`=0.
- R5: With `odd_sel`=0 (even sense), `par_out` is 1 when `a_in` holds an odd number of ones and 0 when it holds an even number.
- R6: With `odd_sel`=1 (odd sense), `par_out` is 1 when `a_in` holds an even number of ones and 0 when it holds an odd number.
- R7: In receive (`dir_a2b`=0, `hiz_req`=0) with `odd_sel`=0, `err_n` is 1 when `b_in` plus `par_in` hold an even number of ones, and 0 otherwise.
- R8: In receive with `odd_sel`=1, `err_n` is 1 when `b_in` plus `par_in` hold an odd number of ones, and 0 otherwise.
- R9: `err_n` is 1 whenever `dir_a2b`=1 or `hiz_req`=1, whatever `b_in` and `par_in` hold.
- R10: Every output takes its new value in the same cycle that an input changes. No register lies on any path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dir_a2b | input | 1 | 1: port A drives port B; 0: port B drives port A |
| hiz_req | input | 1 | 1: release both ports and the parity pin |
| odd_sel | input | 1 | Parity sense, 0 even, 1 odd |
| a_in | input | 8 | Value seen on port A pins |
| a_out | output | 8 | Value driven onto port A |
| a_oe | output | 1 | Drive enable for port A |
| b_in | input | 8 | Value seen on port B pins |
| b_out | output | 8 | Value driven onto port B |
| b_oe | output | 1 | Drive enable for port B |
| par_in | input | 1 | Value seen on the parity pin |
| par_out | output | 1 | Generated parity driven onto the parity pin |
| par_oe | output | 1 | Drive enable for the parity pin |
| err_n | output | 1 | Active-low receive parity error |

## Verification
Every result is due zero cycles after its stimulus, because no path through the block passes through a register. The bench applies each new input set on the falling edge of its clock and samples the outputs one nanosecond later, well before the next rising edge, so each check sees settled combinational values. Expected values come from a bit count done in the bench, not from a reduction XOR. The sweep covers every byte value under each combination of direction, release, parity sense and incoming parity.

// File: rtl/bpt_pkg.sv
package bpt_pkg;

   typedef enum logic {
      XFER_B2A = 1'b0,
      XFER_A2B = 1'b1
   } xfer_dir_e;

   typedef enum logic {
      SENSE_EVEN = 1'b0,
      SENSE_ODD  = 1'b1
   } par_sense_e;

endpackage

// File: rtl/bpt_parity_tree.sv
module bpt_parity_tree #(
   parameter int WIDTH    = 8,
   parameter bit BALANCED = 1'b1
) (
   input  logic [WIDTH-1:0] bits_i,
   output logic             odd_o
);
   localparam int LEAVES = 1 << $clog2(WIDTH);
   localparam int NODES  = 2 * LEAVES - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("bpt_parity_tree: WIDTH must be at least 2");
   end

   if (BALANCED) begin : g_tree
      logic [NODES-1:0] node;
      always_comb begin
         node = '0;
         for (int i = 0; i < WIDTH; i++) begin
            node[LEAVES-1+i] = bits_i[i];
         end
         for (int k = LEAVES - 2; k >= 0; k--) begin
            node[k] = node[2*k+1] ^ node[2*k+2];
         end
      end
      assign odd_o = node[0];
   end else begin : g_flat
      assign odd_o = ^bits_i;
   end

endmodule

// File: rtl/bpt_port_steer.sv
module bpt_port_steer #(
   parameter int WIDTH = 8
) (
   input  bpt_pkg::xfer_dir_e dir_i,
   input  logic               hiz_i,
   input  logic [WIDTH-1:0]   a_in_i,
   input  logic [WIDTH-1:0]   b_in_i,
   output logic [WIDTH-1:0]   a_out_o,
   output logic               a_oe_o,
   output logic [WIDTH-1:0]   b_out_o,
   output logic               b_oe_o,
   output logic               par_oe_o
);
   import bpt_pkg::*;

   logic toward_b;

   assign toward_b = (dir_i == XFER_A2B);

   assign a_out_o  = b_in_i;
   assign b_out_o  = a_in_i;
   assign a_oe_o   = !hiz_i && !toward_b;
   assign b_oe_o   = !hiz_i &&  toward_b;
   assign par_oe_o = !hiz_i &&  toward_b;

endmodule

// File: rtl/bpt_rx_check.sv
module bpt_rx_check (
   input  logic                rx_active_i,
   input  bpt_pkg::par_sense_e sense_i,
   input  logic                data_odd_i,
   input  logic                par_in_i,
   output logic                err_n_o
);
   import bpt_pkg::*;

   logic nine_odd;
   logic match;

   assign nine_odd = data_odd_i ^ par_in_i;
   assign match    = (sense_i == SENSE_ODD) ? nine_odd : !nine_odd;
   assign err_n_o  = rx_active_i ? match : 1'b1;

endmodule

// File: rtl/bpt_xcvr.sv
module bpt_xcvr #(
   parameter int DATA_W       = 8,
   parameter bit BALANCED_PAR = 1'b1
) (
   input  logic              dir_a2b,
   input  logic              hiz_req,
   input  logic              odd_sel,
   input  logic [DATA_W-1:0] a_in,
   output logic [DATA_W-1:0] a_out,
   output logic              a_oe,
   input  logic [DATA_W-1:0] b_in,
   output logic [DATA_W-1:0] b_out,
   output logic              b_oe,
   input  logic              par_in,
   output logic              par_out,
   output logic              par_oe,
   output logic              err_n
);
   import bpt_pkg::*;

   xfer_dir_e  dir_e;
   par_sense_e sense_e;
   logic       a_odd;
   logic       b_odd;
   logic       rx_active;

   assign dir_e     = xfer_dir_e'(dir_a2b);
   assign sense_e   = par_sense_e'(odd_sel);
   assign rx_active = (dir_e == XFER_B2A) && !hiz_req;

   bpt_port_steer #(.WIDTH(DATA_W)) u_steer (
      .dir_i    (dir_e),
      .hiz_i    (hiz_req),
      .a_in_i   (a_in),
      .b_in_i   (b_in),
      .a_out_o  (a_out),
      .a_oe_o   (a_oe),
      .b_out_o  (b_out),
      .b_oe_o   (b_oe),
      .par_oe_o (par_oe)
   );

   bpt_parity_tree #(.WIDTH(DATA_W), .BALANCED(BALANCED_PAR)) u_tree_a (
      .bits_i (a_in),
      .odd_o  (a_odd)
   );

   bpt_parity_tree #(.WIDTH(DATA_W), .BALANCED(BALANCED_PAR)) u_tree_b (
      .bits_i (b_in),
      .odd_o  (b_odd)
   );

   assign par_out = a_odd ^ (sense_e == SENSE_ODD);

   bpt_rx_check u_check (
      .rx_active_i (rx_active),
      .sense_i     (sense_e),
      .data_odd_i  (b_odd),
      .par_in_i    (par_in),
      .err_n_o     (err_n)
   );

   // Immediate checks across the separately built pieces.
   always_comb begin
      assert_hiz_release_R3 : assert (!hiz_req || !(a_oe || b_oe || par_oe))
         else $error("release request left a driver on");
      // R5/R6: the nine bits leaving on port B carry the selected sense
      assert_tx_sense_R5 : assert (!b_oe || ((^{b_out, par_out}) == odd_sel))
         else $error("transmitted nine bits carry the wrong parity sense");
      // R7/R8: a clean flag only when the nine received bits carry the sense
      assert_rx_flag_R7 : assert (!a_oe || (err_n == ((^{a_out, par_in}) == odd_sel)))
         else $error("receive flag disagrees with received parity");
      assert_flag_idle_R9 : assert (a_oe || err_n)
         else $error("error flag low outside receive");
   end

endmodule

// File: tb/bpt_xcvr_test.sv
`timescale 1ns/1ps
module bpt_xcvr_test;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         dir_a2b, hiz_req, odd_sel, par_in;
   logic [W-1:0] a_in, b_in;
   logic [W-1:0] a_out, b_out;
   logic         a_oe, b_oe, par_out, par_oe, err_n;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #2 clk = ~clk;

   bpt_xcvr #(.DATA_W(W)) uut (
      .dir_a2b (dir_a2b),
      .hiz_req (hiz_req),
      .odd_sel (odd_sel),
      .a_in    (a_in),
      .a_out   (a_out),
      .a_oe    (a_oe),
      .b_in    (b_in),
      .b_out   (b_out),
      .b_oe    (b_oe),
      .par_in  (par_in),
      .par_out (par_out),
      .par_oe  (par_oe),
      .err_n   (err_n)
   );

   function automatic int ones(input logic [W-1:0] v);
      int n = 0;
      for (int i = 0; i < W; i++) n += int'(v[i]);
      return n;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d dir=%0b hiz=%0b odd=%0b a=%0h b=%0h p=%0b",
                  req, act, exp, dir_a2b, hiz_req, odd_sel, a_in, b_in, par_in);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      dir_a2b = 1'b0; hiz_req = 1'b1; odd_sel = 1'b0; par_in = 1'b0;
      a_in = '0; b_in = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      #1;
      // Reset-time state: released, so nothing drives and the flag is idle
      check(!a_oe && !b_oe && !par_oe, "R3 initial release", {a_oe, b_oe, par_oe}, 0);
      check(err_n == 1'b1, "R9 initial flag", err_n, 1);

      for (int d = 0; d < 2; d++)
      for (int h = 0; h < 2; h++)
      for (int o = 0; o < 2; o++)
      for (int p = 0; p < 2; p++)
      for (int v = 0; v < 256; v++) begin
         @(negedge clk);
         dir_a2b = d[0]; hiz_req = h[0]; odd_sel = o[0]; par_in = p[0];
         a_in    = v[W-1:0];
         b_in    = v[W-1:0] ^ 8'h5A ^ {W{p[0]}};
         #1;  // R10: same-cycle response, sampled before the next rising edge
         begin
            logic exp_aoe, exp_boe, exp_poe, exp_par, exp_err_n;
            int   a_cnt, nine_cnt;
            a_cnt    = ones(a_in);
            nine_cnt = ones(b_in) + p;
            exp_aoe  = (d == 0) && (h == 0);
            exp_boe  = (d == 1) && (h == 0);
            exp_poe  = exp_boe;
            exp_par  = (o == 0) ? (a_cnt % 2 == 1) : (a_cnt % 2 == 0);
            if (d == 1 || h == 1) exp_err_n = 1'b1;
            else if (o == 0)      exp_err_n = (nine_cnt % 2 == 0);
            else                  exp_err_n = (nine_cnt % 2 == 1);

            if (h == 1)
               check({a_oe, b_oe, par_oe} == 3'b000, "R3 release", {a_oe, b_oe, par_oe}, 0);
            else if (d == 1) begin
               check(b_oe && !a_oe, "R1 transmit enables", {a_oe, b_oe}, 1);
               check(b_out == a_in, "R1 transmit data", b_out, a_in);
            end else begin
               check(a_oe && !b_oe, "R2 receive enables", {a_oe, b_oe}, 2);
               check(a_out == b_in, "R2 receive data", a_out, b_in);
            end
            check(a_oe == exp_aoe && b_oe == exp_boe, "R10 enables settle", {a_oe, b_oe},
                  {exp_aoe, exp_boe});
            check(par_oe == exp_poe, "R4 parity pin enable", par_oe, exp_poe);
            if (o == 0)
               check(par_out == exp_par, "R5 even generation", par_out, exp_par);
            else
               check(par_out == exp_par, "R6 odd generation", par_out, exp_par);
            if (d == 1 || h == 1)
               check(err_n == 1'b1, "R9 idle flag", err_n, 1);
            else if (o == 0)
               check(err_n == exp_err_n, "R7 even check", err_n, exp_err_n);
            else
               check(err_n == exp_err_n, "R8 odd check", err_n, exp_err_n);
         end
      end

      // Boundary bytes in receive, both senses
      @(negedge clk);
      dir_a2b = 1'b0; hiz_req = 1'b0; odd_sel = 1'b0; b_in = 8'hFF; par_in = 1'b1;
      #1 check(err_n == 1'b0, "R7 all ones plus high parity", err_n, 0);
      @(negedge clk);
      odd_sel = 1'b1; b_in = 8'h00; par_in = 1'b1;
      #1 check(err_n == 1'b1, "R8 zero byte plus high parity", err_n, 1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule